// File: doc/BRIEF.md
# Circuit-Switched Stream Switch Node

This block is one node in a chain of switches that carries word streams between compute modules. Each node has one attached module. It is linked to its right-hand neighbour by a bundle of rightward channels and to its left-hand neighbour by a bundle of leftward channels. A module opens a circuit with a header word that carries a destination node number. Each node on the way reserves one outgoing channel for that stream, picking the direction by comparing the destination with its own number. Every later word of the stream then passes straight through on the reserved path, without any further routing decision. An end word closes the circuit, and each node frees its channel as the end word goes past.

All ports use valid/ready handshakes. The data path through a node is combinational once a circuit is set up, so a consumer that holds ready low stalls the whole circuit back to the producer and no word is lost. Setting up a circuit costs one cycle per node. The node exposes a bitmap of its reserved outgoing channels.

Top module: `stream_circuit_switch`

## Requirements
- R1: The direction comes from the low IDW bits of the header payload (the destination), compared with NODE_ID. A destination above NODE_ID reserves a rightward channel. A destination below NODE_ID reserves a leftward channel. An equal destination reserves the local output.
- R2: Within the chosen direction, the node reserves the lowest-numbered channel that is free.
- R3: Word types use a 2-bit tag: 00 data, 01 header, 10 end. A header arriving on an idle input with a free channel is accepted one cycle after it is first presented. It is forwarded on the reserved rightward or leftward channel. When the destination is this node, it is consumed and never shown on the local output.
- R4: Once a circuit is set up, each data word and end word appears unchanged on the reserved output in the same cycle that it is offered.
- R5: Transferring an end word releases the circuit. The channel's busy bit is clear from the next cycle on.
- R6: When no channel is free in the required direction, the header is held with ready low. It is not dropped, and it takes a channel once one is released.
- R7: When the reserved output has ready low, the input's ready is low, the word stays visible on the output, and the reservation is kept.
- R8: When several idle inputs offer headers for the same direction in one cycle, a round-robin pointer chooses the winner. The search starts at the input after the previous winner. Inputs are numbered: local 0, rightward inputs 1..NLR, leftward inputs after those.
- R9: A data or end word offered on an input that holds no circuit is accepted at once and discarded, with no output activity.
- R10: Synchronous reset clears all reservations. The busy outputs show one bit per outgoing channel, set exactly while that channel is reserved.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| loc_in_data | input | DW | Word from attached module |
| loc_in_type | input | 2 | Type tag of module word |
| loc_in_valid | input | 1 | Module word valid |
| loc_in_ready | output | 1 | Module word accepted |
| lr_in_data | input | NLR*DW | Words arriving from the left neighbour, channel i at bits i*DW |
| lr_in_type | input | NLR*2 | Their type tags |
| lr_in_valid | input | NLR | Their valids |
| lr_in_ready | output | NLR | Their readies |
| rl_in_data | input | NRL*DW | Words arriving from the right neighbour |
| rl_in_type | input | NRL*2 | Their type tags |
| rl_in_valid | input | NRL | Their valids |
| rl_in_ready | output | NRL | Their readies |
| lr_out_data | output | NLR*DW | Rightward channel words |
| lr_out_type | output | NLR*2 | Rightward channel type tags |
| lr_out_valid | output | NLR | Rightward channel valids |
| lr_out_ready | input | NLR | Rightward channel readies |
| rl_out_data | output | NRL*DW | Leftward channel words |
| rl_out_type | output | NRL*2 | Leftward channel type tags |
| rl_out_valid | output | NRL | Leftward channel valids |
| rl_out_ready | input | NRL | Leftward channel readies |
| loc_out_data | output | DW | Word delivered to module |
| loc_out_type | output | 2 | Its type tag |
| loc_out_valid | output | 1 | Delivered word valid |
| loc_out_ready | input | 1 | Module accepts word |
| lr_busy | output | NLR | Rightward channels reserved |
| rl_busy | output | NRL | Leftward channels reserved |
| loc_busy | output | 1 | Local output reserved |

## Verification
The hardest situations to reach are those where the node's state matters more than the word being offered. One is a header waiting while every channel in its direction is held. Another is two headers arriving together after the round-robin pointer has moved away from zero. To reach the first, the stimulus leaves circuits half-open: it sends a header and a data word and then withholds the end word, which fills both rightward channels before a third header arrives. To reach the second, it first runs a full stream from a high-numbered input to move the pointer, then offers headers on two inputs, where a fixed lowest-first priority would choose the other input. Directions are covered by a sweep of every input against every destination from 0 to 4, with the expected channel derived from the comparison rule.

// File: rtl/stream_circuit_switch.sv
module stream_circuit_switch #(
  parameter int DW      = 32,
  parameter int NLR     = 2,
  parameter int NRL     = 2,
  parameter int IDW     = 4,
  parameter int NODE_ID = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DW-1:0]     loc_in_data,
  input  logic [1:0]        loc_in_type,
  input  logic              loc_in_valid,
  output logic              loc_in_ready,
  input  logic [NLR*DW-1:0] lr_in_data,
  input  logic [NLR*2-1:0]  lr_in_type,
  input  logic [NLR-1:0]    lr_in_valid,
  output logic [NLR-1:0]    lr_in_ready,
  input  logic [NRL*DW-1:0] rl_in_data,
  input  logic [NRL*2-1:0]  rl_in_type,
  input  logic [NRL-1:0]    rl_in_valid,
  output logic [NRL-1:0]    rl_in_ready,
  output logic [NLR*DW-1:0] lr_out_data,
  output logic [NLR*2-1:0]  lr_out_type,
  output logic [NLR-1:0]    lr_out_valid,
  input  logic [NLR-1:0]    lr_out_ready,
  output logic [NRL*DW-1:0] rl_out_data,
  output logic [NRL*2-1:0]  rl_out_type,
  output logic [NRL-1:0]    rl_out_valid,
  input  logic [NRL-1:0]    rl_out_ready,
  output logic [DW-1:0]     loc_out_data,
  output logic [1:0]        loc_out_type,
  output logic              loc_out_valid,
  input  logic              loc_out_ready,
  output logic [NLR-1:0]    lr_busy,
  output logic [NRL-1:0]    rl_busy,
  output logic              loc_busy
);
  localparam int S   = 1 + NLR + NRL;
  localparam int O   = NLR + NRL + 1;
  localparam int LOC = NLR + NRL;
  localparam int SW  = $clog2(S);
  localparam int OW  = $clog2(O);
  localparam logic [1:0] T_HDR = 2'b01;
  localparam logic [1:0] T_END = 2'b10;
  localparam logic [IDW-1:0] MY_ID = IDW'(NODE_ID);

  function automatic logic [1:0] want_grp(input logic [DW-1:0] w);
    if (w[IDW-1:0] > MY_ID) return 2'd0;
    if (w[IDW-1:0] < MY_ID) return 2'd1;
    return 2'd2;
  endfunction

  function automatic logic [1:0] out_grp(input int o);
    if (o < NLR) return 2'd0;
    if (o < LOC) return 2'd1;
    return 2'd2;
  endfunction

  logic [DW-1:0] s_data [S];
  logic [1:0]    s_type [S];
  logic [1:0]    s_grp  [S];
  logic [S-1:0]  s_valid, s_ready, hreq, act;
  logic [OW-1:0] sel    [S];

  logic [DW-1:0] o_data [O];
  logic [1:0]    o_type [O];
  logic [O-1:0]  o_valid, o_ready, busy;
  logic [SW-1:0] owner  [O];

  logic [SW-1:0] rr     [3];
  logic [2:0]    fr_any, gnt_v;
  logic [OW-1:0] fr_idx [3];
  logic [SW-1:0] gnt_s  [3];

  assign s_data[0]    = loc_in_data;
  assign s_type[0]    = loc_in_type;
  assign s_valid[0]   = loc_in_valid;
  assign loc_in_ready = s_ready[0];

  for (genvar i = 0; i < NLR; i++) begin : g_lr
    assign s_data[1+i]     = lr_in_data[i*DW +: DW];
    assign s_type[1+i]     = lr_in_type[i*2 +: 2];
    assign s_valid[1+i]    = lr_in_valid[i];
    assign lr_in_ready[i]  = s_ready[1+i];
    assign lr_out_data[i*DW +: DW] = o_data[i];
    assign lr_out_type[i*2 +: 2]   = o_type[i];
    assign lr_out_valid[i] = o_valid[i];
    assign o_ready[i]      = lr_out_ready[i];
  end

  for (genvar i = 0; i < NRL; i++) begin : g_rl
    assign s_data[1+NLR+i]  = rl_in_data[i*DW +: DW];
    assign s_type[1+NLR+i]  = rl_in_type[i*2 +: 2];
    assign s_valid[1+NLR+i] = rl_in_valid[i];
    assign rl_in_ready[i]   = s_ready[1+NLR+i];
    assign rl_out_data[i*DW +: DW] = o_data[NLR+i];
    assign rl_out_type[i*2 +: 2]   = o_type[NLR+i];
    assign rl_out_valid[i]  = o_valid[NLR+i];
    assign o_ready[NLR+i]   = rl_out_ready[i];
  end

  assign loc_out_data  = o_data[LOC];
  assign loc_out_type  = o_type[LOC];
  assign loc_out_valid = o_valid[LOC];
  assign o_ready[LOC]  = loc_out_ready;

  assign lr_busy  = busy[NLR-1:0];
  assign rl_busy  = busy[LOC-1:NLR];
  assign loc_busy = busy[LOC];

  for (genvar s = 0; s < S; s++) begin : g_req
    assign hreq[s]  = s_valid[s] && !act[s] && s_type[s] == T_HDR;
    assign s_grp[s] = want_grp(s_data[s]);
  end

  for (genvar o = 0; o < O; o++) begin : g_xbar
    assign o_data[o] = s_data[owner[o]];
    assign o_type[o] = s_type[owner[o]];
  end

  always_comb begin
    for (int o = 0; o < O; o++) begin
      o_valid[o] = busy[o] && s_valid[owner[o]];
      if (o == LOC && s_type[owner[o]] == T_HDR) o_valid[o] = 1'b0;
    end
    for (int s = 0; s < S; s++) begin
      if (!act[s])
        s_ready[s] = s_type[s] != T_HDR;
      else if (sel[s] == OW'(LOC) && s_type[s] == T_HDR)
        s_ready[s] = 1'b1;
      else
        s_ready[s] = o_ready[sel[s]];
    end
  end

  always_comb begin
    int idx;
    for (int g = 0; g < 3; g++) begin
      fr_any[g] = 1'b0;
      fr_idx[g] = '0;
      for (int o = O - 1; o >= 0; o--) begin
        if (out_grp(o) == 2'(g) && !busy[o]) begin
          fr_any[g] = 1'b1;
          fr_idx[g] = OW'(o);
        end
      end
      gnt_v[g] = 1'b0;
      gnt_s[g] = '0;
      for (int k = 0; k < S; k++) begin
        idx = int'(rr[g]) + k;
        if (idx >= S) idx = idx - S;
        if (!gnt_v[g] && fr_any[g] && hreq[idx] && s_grp[idx] == 2'(g)) begin
          gnt_v[g] = 1'b1;
          gnt_s[g] = SW'(idx);
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      act  <= '0;
      busy <= '0;
      for (int g = 0; g < 3; g++) rr[g] <= '0;
      for (int s = 0; s < S; s++) sel[s] <= '0;
      for (int o = 0; o < O; o++) owner[o] <= '0;
    end else begin
      for (int s = 0; s < S; s++) begin
        if (act[s] && s_valid[s] && s_ready[s] && s_type[s] == T_END) begin
          act[s]       <= 1'b0;
          busy[sel[s]] <= 1'b0;
        end
      end
      for (int g = 0; g < 3; g++) begin
        if (gnt_v[g]) begin
          act[gnt_s[g]]    <= 1'b1;
          sel[gnt_s[g]]    <= fr_idx[g];
          busy[fr_idx[g]]  <= 1'b1;
          owner[fr_idx[g]] <= gnt_s[g];
          rr[g] <= (int'(gnt_s[g]) == S - 1) ? '0 : gnt_s[g] + 1'b1;
        end
      end
    end
  end

  // R3
  hdr_consumed_chk: assert property (@(posedge clk) disable iff (rst)
    loc_out_valid |-> loc_out_type != T_HDR);

  for (genvar s = 0; s < S; s++) begin : g_src_chk
    // R5
    release_chk: assert property (@(posedge clk) disable iff (rst)
      (act[s] && s_valid[s] && s_ready[s] && s_type[s] == T_END)
      |=> (!act[s] && !busy[$past(sel[s])]));
    // R6
    blocked_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (hreq[s] && !fr_any[s_grp[s]]) |=> !act[s]);
  end

  for (genvar o = 0; o < O; o++) begin : g_out_chk
    // R7
    stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (o_valid[o] && !o_ready[o]) |=> (busy[o] && $stable(owner[o])));
    // R10
    owner_link_chk: assert property (@(posedge clk) disable iff (rst)
      busy[o] |-> (act[owner[o]] && sel[owner[o]] == OW'(o)));
  end
endmodule

// File: tb/test_stream_circuit_switch.sv
module test_stream_circuit_switch;
  localparam int CLK_P = 10;
  localparam int DW = 32, NLR = 2, NRL = 2, IDW = 4, NID = 2;
  localparam logic [1:0] DAT = 2'b00, HDR = 2'b01, ENDW = 2'b10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #(CLK_P/2) clk = ~clk;

  logic [31:0] sd [5];
  logic [1:0]  st [5];
  logic [4:0]  sv;
  logic [4:0]  ordy;

  logic [1:0]  loc_in_ready_w;
  logic        loc_in_ready;
  logic [NLR-1:0] lr_in_ready, lr_out_valid, lr_busy;
  logic [NRL-1:0] rl_in_ready, rl_out_valid, rl_busy;
  logic [NLR*DW-1:0] lr_out_data;
  logic [NRL*DW-1:0] rl_out_data;
  logic [NLR*2-1:0]  lr_out_type;
  logic [NRL*2-1:0]  rl_out_type;
  logic [DW-1:0] loc_out_data;
  logic [1:0]    loc_out_type;
  logic          loc_out_valid, loc_busy;

  stream_circuit_switch #(.DW(DW), .NLR(NLR), .NRL(NRL), .IDW(IDW), .NODE_ID(NID)) i_stream_circuit_switch (
    .clk(clk), .rst(rst),
    .loc_in_data(sd[0]), .loc_in_type(st[0]), .loc_in_valid(sv[0]), .loc_in_ready(loc_in_ready),
    .lr_in_data({sd[2], sd[1]}), .lr_in_type({st[2], st[1]}), .lr_in_valid(sv[2:1]), .lr_in_ready(lr_in_ready),
    .rl_in_data({sd[4], sd[3]}), .rl_in_type({st[4], st[3]}), .rl_in_valid(sv[4:3]), .rl_in_ready(rl_in_ready),
    .lr_out_data(lr_out_data), .lr_out_type(lr_out_type), .lr_out_valid(lr_out_valid), .lr_out_ready(ordy[1:0]),
    .rl_out_data(rl_out_data), .rl_out_type(rl_out_type), .rl_out_valid(rl_out_valid), .rl_out_ready(ordy[3:2]),
    .loc_out_data(loc_out_data), .loc_out_type(loc_out_type), .loc_out_valid(loc_out_valid), .loc_out_ready(ordy[4]),
    .lr_busy(lr_busy), .rl_busy(rl_busy), .loc_busy(loc_busy)
  );

  wire [4:0] srdy = {rl_in_ready, lr_in_ready, loc_in_ready};
  wire [4:0] ovld = {loc_out_valid, rl_out_valid, lr_out_valid};
  assign loc_in_ready_w = '0;

  int ntests = 0, nfail = 0;

  function automatic logic [31:0] odat(input int o);
    if (o < 2) return lr_out_data[o*32 +: 32];
    if (o < 4) return rl_out_data[(o-2)*32 +: 32];
    return loc_out_data;
  endfunction

  function automatic logic [1:0] otyp(input int o);
    if (o < 2) return lr_out_type[o*2 +: 2];
    if (o < 4) return rl_out_type[(o-2)*2 +: 2];
    return loc_out_type;
  endfunction

  function automatic logic [4:0] busyv();
    return {loc_busy, rl_busy, lr_busy};
  endfunction

  task automatic chk(input bit ok, input string rq, input string what, input longint a, input longint e);
    ntests++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, a, e);
    end
  endtask

  task automatic put(input int s, input logic [1:0] t, input logic [31:0] d, input int eo,
                     input string rq, output int w);
    sd[s] = d; st[s] = t; sv[s] = 1'b1; w = 0;
    #1;
    while (!srdy[s] && w < 30) begin
      @(negedge clk); #1; w++;
    end
    chk(srdy[s] == 1'b1, rq, "input accepted", srdy[s], 1);
    if (eo >= 0) begin
      chk(ovld[eo] == 1'b1, rq, "output valid", ovld, 5'(1 << eo));
      chk(odat(eo) == d && otyp(eo) == t, rq, "output word", odat(eo), d);
    end else begin
      chk(ovld == 5'b0, rq, "no output", ovld, 0);
    end
    @(posedge clk); @(negedge clk);
    sv[s] = 1'b0;
  endtask

  task automatic do_reset();
    sv = '0; ordy = '1; rst = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    #(CLK_P * 50000);
    nfail++; ntests++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", ntests, nfail);
    $finish;
  end

  initial begin
    int w;
    for (int i = 0; i < 5; i++) begin sd[i] = '0; st[i] = DAT; end
    do_reset();
    #1;
    // R10
    chk(busyv() == 5'b0, "R10", "busy after reset", busyv(), 0);
    chk(ovld == 5'b0, "R10", "valid after reset", ovld, 0);
    @(negedge clk);

    // R1 R3 R4 R5: every input against every destination
    for (int s = 0; s < 5; s++) begin
      for (int d = 0; d < 5; d++) begin
        int eob, eoh;
        eob = (d > NID) ? 0 : (d < NID) ? 2 : 4;
        eoh = (eob == 4) ? -1 : eob;
        put(s, HDR, 32'hA5A5_0000 | d, eoh, "R3", w);
        chk(w == 1, "R3", "setup cycles", w, 1);
        chk(busyv() == 5'(1 << eob), "R1", "reserved channel", busyv(), 1 << eob);
        for (int k = 0; k < 2; k++)
          put(s, DAT, {8'(s), 8'(d), 16'(k + 7)}, eob, "R4", w);
        put(s, ENDW, 32'hE0D0_0000 | d, eob, "R5", w);
        #1;
        chk(busyv() == 5'b0, "R5", "released", busyv(), 0);
        @(negedge clk);
      end
    end

    // R2 R6: fill both rightward channels, block a third header
    put(0, HDR, 32'h0000_0004, 0, "R2", w);
    put(0, DAT, 32'h1111_0000, 0, "R2", w);
    put(1, HDR, 32'h0000_0003, 1, "R2", w);
    put(1, DAT, 32'h2222_0000, 1, "R2", w);
    #1;
    chk(busyv() == 5'b00011, "R2", "both rightward held", busyv(), 3);
    sd[2] = 32'h0000_0005; st[2] = HDR; sv[2] = 1'b1;
    for (int c = 0; c < 5; c++) begin
      #1;
      chk(srdy[2] == 1'b0, "R6", "blocked header ready", srdy[2], 0);
      chk(ovld == 5'b0, "R6", "blocked no output", ovld, 0);
      @(negedge clk);
    end
    put(0, ENDW, 32'hEEEE_0000, 0, "R5", w);
    #1;
    chk(busyv() == 5'b00010, "R5", "ch0 freed", busyv(), 2);
    put(2, HDR, 32'h0000_0005, 0, "R6", w);
    chk(w == 1, "R6", "waiting header taken", w, 1);
    put(2, ENDW, 32'hEEEE_0002, 0, "R2", w);
    put(1, ENDW, 32'hEEEE_0001, 1, "R5", w);
    #1;
    chk(busyv() == 5'b0, "R5", "all freed", busyv(), 0);
    @(negedge clk);

    // R7: backpressure on leftward channel 0
    put(3, HDR, 32'h0000_0000, 2, "R7", w);
    ordy[2] = 1'b0;
    sd[3] = 32'hBEEF_0003; st[3] = DAT; sv[3] = 1'b1;
    for (int c = 0; c < 3; c++) begin
      #1;
      chk(srdy[3] == 1'b0, "R7", "stalled input ready", srdy[3], 0);
      chk(ovld[2] == 1'b1 && odat(2) == 32'hBEEF_0003, "R7", "held word", odat(2), 32'hBEEF_0003);
      chk(busyv() == 5'b00100, "R7", "kept reservation", busyv(), 4);
      @(negedge clk);
    end
    ordy[2] = 1'b1;
    put(3, DAT, 32'hBEEF_0003, 2, "R7", w);
    put(3, ENDW, 32'hBEEF_00EE, 2, "R7", w);

    // R8: move pointer past input 3, then inputs 1 and 4 contend
    do_reset();
    put(3, HDR, 32'h0000_0002, -1, "R8", w);
    put(3, ENDW, 32'h0000_0E03, 4, "R8", w);
    sd[1] = 32'h0000_0002; st[1] = HDR; sv[1] = 1'b1;
    sd[4] = 32'h0000_0002; st[4] = HDR; sv[4] = 1'b1;
    #1;
    chk(srdy[1] == 1'b0 && srdy[4] == 1'b0, "R8", "both wait first", srdy, 0);
    @(negedge clk); #1;
    chk(srdy[4] == 1'b1 && srdy[1] == 1'b0, "R8", "round-robin winner", srdy, 5'b10000);
    put(4, HDR, 32'h0000_0002, -1, "R8", w);
    put(4, ENDW, 32'h0000_0E04, 4, "R8", w);
    put(1, HDR, 32'h0000_0002, -1, "R8", w);
    chk(w == 1, "R8", "loser served next", w, 1);
    put(1, ENDW, 32'h0000_0E01, 4, "R8", w);

    // R9: stray word on idle input
    put(2, DAT, 32'h1234_5678, -1, "R9", w);
    chk(w == 0, "R9", "stray accepted at once", w, 0);
    put(0, ENDW, 32'h8765_4321, -1, "R9", w);
    #1;
    chk(busyv() == 5'b0, "R9", "no reservation", busyv(), 0);

    $display("[TB] %0d tests run, %0d failed", ntests, nfail);
    $finish;
  end
endmodule